// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM. The host presents one access at a time on a request/acknowledge port. The controller turns each access into a strobe sequence on the memory pins. That sequence covers two chip selects of opposite polarity, an active-low output enable and an active-low write strobe. When a read finishes, the controller returns the captured byte and raises a one-cycle done pulse. A write finishes with the same pulse.

The memory has no clock, so every minimum interval the memory demands is counted in controller clocks. Each interval is the required nanoseconds divided by the clock period, rounded up, and is never less than one cycle. A write always ends with the write strobe rising while both selects stay asserted. After that edge, address and write data are held for one more clock. The data bus has separate drive, enable and sense signals for a pad-level tri-state buffer. The controller drives it only while it owns the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low: mem_ce1_no=1, mem_ce2_o=0, mem_oe_no=1, mem_we_no=1, mem_dq_oe_o=0, done_o=0, ready_o=1 and rdata_o=0.
- R2: The memory is selected only when mem_ce1_no=0 and mem_ce2_o=1, and the two selects always change together, so the pins never show a partly selected state.
- R3: A read accepted at a clock edge holds select active, mem_oe_no=0 and mem_we_no=1 for RD_CYC cycles. RD_CYC is the largest of the cycle counts for the read cycle, address access and output-enable access times; it is 7 at the defaults. At the end of that window mem_dq_i is captured into rdata_o, and the strobes are released in the same edge.
- R4: A write holds select active, mem_oe_no=1, mem_we_no=0 and mem_dq_oe_o=1 with the write byte on mem_dq_o for WP_CYC cycles. WP_CYC is the largest of the cycle counts for the write pulse width, the address setup and the data setup to the end of the write. It is also at least the write cycle count minus one. It is 6 at the defaults.
- R5: mem_dq_oe_o is never high while mem_oe_no is low.
- R6: A write accepted when the previous access was a read first spends TURN_CYC cycles with all strobes inactive and the bus released before the write strobe falls. TURN_CYC is the cycle count of the memory's output-disable time; it is 3 at the defaults.
- R7: mem_addr_o does not change while the memory stays selected.
- R8: A request is taken only in a cycle where ready_o=1. Requests while ready_o=0 have no effect on any memory pin or on the number of done pulses.
- R9: done_o is high for exactly one cycle per access: in the cycle after the read capture, or in the cycle after the write hold cycle. ready_o is high in that cycle and whenever no access is in progress.
- R10: The write ends by mem_we_no rising while both selects are still asserted. Address and data are held for one cycle after that edge, and only then is the memory deselected.
- R11: Each cycle count is ceil(ns / CLK_PERIOD_NS) with a minimum of 1. At the 8 ns default period this gives a 7-cycle read output-enable window and a 6-cycle write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host byte address |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Last byte read |
| done_o | output | 1 | One-cycle completion pulse |
| ready_o | output | 1 | Controller idle, request may be presented |
| mem_addr_o | output | 17 | Memory address pins |
| mem_ce1_no | output | 1 | Memory select, active low |
| mem_ce2_o | output | 1 | Memory select, active high |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Enable of the data bus driver |
| mem_dq_i | input | 8 | Data sensed from the memory bus |

## Verification
On every cycle the assertions check four properties: the two selects move as a pair, the controller never drives the bus while the output enable is low, the address stays steady under select, and the write strobe rises while the memory is still selected. Done is also checked to be a single-cycle pulse. Only the bench scenarios can show the exact strobe window lengths, the turnaround inserted after a read, the captured read bytes and the dropping of requests made while busy. The bench compares these against a queue-based model of the expected pin sequence. The scenarios cover addresses at both ends of the range, back-to-back reads and writes, and read-to-write transitions.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WPULSE,
    ST_WHOLD
  } state_e;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WP_CYC   = 6,
  parameter int unsigned TURN_CYC = 3,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ce1_no,
  output logic             ce2_o,
  output logic             oe_no,
  output logic             we_no,
  output logic             dq_oe_o,
  output logic             done_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  state_e state_q;
  logic   last_rd_q;
  logic   turn_end;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o && req_i;
  assign turn_end  = (state_q == ST_TURN) && zero_i;
  assign capture_o = (state_q == ST_READ) && zero_i;

  always_comb begin
    load_o     = accept_o || turn_end;
    load_val_o = WP_LD;
    if (accept_o && !we_i)          load_val_o = RD_LD;
    else if (accept_o && last_rd_q) load_val_o = TURN_LD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
      ce1_no    <= 1'b1;
      ce2_o     <= 1'b0;
      oe_no     <= 1'b1;
      we_no     <= 1'b1;
      dq_oe_o   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          if (!we_i) begin
            state_q   <= ST_READ;
            last_rd_q <= 1'b1;
            ce1_no    <= 1'b0;
            ce2_o     <= 1'b1;
            oe_no     <= 1'b0;
          end else begin
            last_rd_q <= 1'b0;
            if (last_rd_q) begin
              state_q <= ST_TURN;  // let the memory release the bus
            end else begin
              state_q <= ST_WPULSE;
              ce1_no  <= 1'b0;
              ce2_o   <= 1'b1;
              we_no   <= 1'b0;
              dq_oe_o <= 1'b1;
            end
          end
        end
        ST_READ: if (zero_i) begin
          state_q <= ST_IDLE;
          ce1_no  <= 1'b1;
          ce2_o   <= 1'b0;
          oe_no   <= 1'b1;
          done_o  <= 1'b1;
        end
        ST_TURN: if (zero_i) begin
          state_q <= ST_WPULSE;
          ce1_no  <= 1'b0;
          ce2_o   <= 1'b1;
          we_no   <= 1'b0;
          dq_oe_o <= 1'b1;
        end
        ST_WPULSE: if (zero_i) begin
          state_q <= ST_WHOLD;
          we_no   <= 1'b1;  // write ends on the strobe, selects stay on
        end
        ST_WHOLD: begin
          state_q <= ST_IDLE;
          ce1_no  <= 1'b1;
          ce2_o   <= 1'b0;
          dq_oe_o <= 1'b0;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_ce_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce1_no == !ce2_o);

  assert_no_drive_under_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_no);

  assert_we_rise_selected_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (!ce1_no && ce2_o && dq_oe_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_oe_we_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !we_no));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  // sample before the address can move (output hold is only a few ns)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= mem_dq_i;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_DOE_NS      = 25,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_PWE_NS      = 40,
  parameter int unsigned T_AW_NS       = 45,
  parameter int unsigned T_SD_NS       = 25,
  parameter int unsigned T_HZ_NS       = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  // R11: all windows derived from the period
  localparam int unsigned RD_CYC = max2(max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                                        ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS));
  localparam int unsigned WC_CYC = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC = max2(max2(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                        max2(ns_to_cyc(T_SD_NS, CLK_PERIOD_NS),
                                             (WC_CYC > 1) ? WC_CYC - 1 : 1));
  localparam int unsigned TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WP_CYC), TURN_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;
  logic             accept;
  logic             capture;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sram_ctrl_fsm #(
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce1_no     (mem_ce1_no),
    .ce2_o      (mem_ce2_o),
    .oe_no      (mem_oe_no),
    .we_no      (mem_we_no),
    .dq_oe_o    (mem_dq_oe_o),
    .done_o     (done_o),
    .ready_o    (ready_o)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o)
  );

  assert_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce1_no && $past(!mem_ce1_no)) |-> $stable(mem_addr_o));

  assert_data_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int RD_EXP   = 7;  // ceil(55/8)
  localparam int WP_EXP   = 6;  // max(ceil(40/8), ceil(45/8), ceil(25/8), ceil(55/8)-1)
  localparam int TURN_EXP = 3;  // ceil(20/8)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, mem_dq_o, mem_dq_i;
  logic        done, ready, ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [16:0] mem_addr;

  int checks = 0, errors = 0, cycles = 0, dones = 0;

  always #4 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .ready_o(ready),
    .mem_addr_o(mem_addr), .mem_ce1_no(ce1_n), .mem_ce2_o(ce2),
    .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  // device model and independent shadow
  logic [7:0] dev_mem [int];
  logic [7:0] sh_mem  [int];

  function automatic logic [7:0] init_val(logic [16:0] a);
    return a[7:0] ^ {1'b0, a[16:10]} ^ 8'h5A;
  endfunction

  wire dev_sel   = !ce1_n && ce2;
  wire dev_drive = dev_sel && !oe_n && we_n;

  always_comb begin
    if (dev_drive)
      mem_dq_i = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : init_val(mem_addr);
    else
      mem_dq_i = 8'hEE;
  end

  always @(posedge clk) if (rst_n && dev_sel && !we_n && dq_oe) dev_mem[int'(mem_addr)] = mem_dq_o;

  // expected pin sequence model
  typedef struct {
    bit          sel, oe_n, we_n, drv, done, ready, rd_upd;
    logic [16:0] a;
    logic [7:0]  d;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  bit   last_rd = 0;
  logic [7:0] exp_rd = '0;

  function automatic exp_t idle_e();
    exp_t e;
    e.sel = 0; e.oe_n = 1; e.we_n = 1; e.drv = 0; e.done = 0; e.ready = 1;
    e.rd_upd = 0; e.a = '0; e.d = '0; e.tag = "R9";
    return e;
  endfunction

  function automatic exp_t busy_e(bit s, bit o, bit w, bit dr, logic [16:0] a, logic [7:0] d, string t);
    exp_t e = idle_e();
    e.sel = s; e.oe_n = o; e.we_n = w; e.drv = dr; e.ready = 0; e.a = a; e.d = d; e.tag = t;
    return e;
  endfunction

  initial cur = idle_e();

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); cur = idle_e(); last_rd = 0; exp_rd = '0;
    end else begin
      if (cur.ready && req) begin  // R8: only taken when idle
        exp_t e;
        if (!we) begin
          for (int i = 0; i < RD_EXP; i++) q.push_back(busy_e(1, 0, 1, 0, addr, 8'h00, "R3"));
          e = idle_e(); e.done = 1; e.rd_upd = 1;
          e.d = sh_mem.exists(int'(addr)) ? sh_mem[int'(addr)] : init_val(addr);
          q.push_back(e);
          last_rd = 1;
        end else begin
          if (last_rd)
            for (int i = 0; i < TURN_EXP; i++) q.push_back(busy_e(0, 1, 1, 0, addr, wdata, "R6"));
          for (int i = 0; i < WP_EXP; i++) q.push_back(busy_e(1, 1, 0, 1, addr, wdata, "R4"));
          q.push_back(busy_e(1, 1, 1, 1, addr, wdata, "R10"));
          e = idle_e(); e.done = 1;
          q.push_back(e);
          sh_mem[int'(addr)] = wdata;
          last_rd = 0;
        end
      end
      cur = (q.size() != 0) ? q.pop_front() : idle_e();
      if (cur.rd_upd) exp_rd = cur.d;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // compare every cycle, away from the active edge
  int oe_run = 0, we_run = 0;
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R1", "ce1_n", ce1_n, 1); chk("R1", "ce2", ce2, 0);
      chk("R1", "oe_n", oe_n, 1);   chk("R1", "we_n", we_n, 1);
      chk("R1", "dq_oe", dq_oe, 0); chk("R1", "done", done, 0);
      chk("R1", "ready", ready, 1); chk("R1", "rdata", rdata, 0);
    end else begin
      chk(cur.tag, "ce1_n", ce1_n, !cur.sel);
      chk("R2", "ce2", ce2, cur.sel);
      chk(cur.tag, "oe_n", oe_n, cur.oe_n);
      chk(cur.tag, "we_n", we_n, cur.we_n);
      chk(cur.tag, "dq_oe", dq_oe, cur.drv);
      chk("R9", "done", done, cur.done);
      chk("R9", "ready", ready, cur.ready);
      chk("R3", "rdata", rdata, exp_rd);
      if (cur.sel) chk("R7", "addr", mem_addr, cur.a);
      if (cur.drv) chk("R4", "dq_o", mem_dq_o, cur.d);
      if (dev_drive && dq_oe) chk("R5", "bus contention", 1, 0);
      if (done) dones++;
      // R11: measured strobe windows
      if (!oe_n) oe_run++;
      else if (oe_run != 0) begin chk("R11", "oe low cycles", oe_run, RD_EXP); oe_run = 0; end
      if (!we_n) we_run++;
      else if (we_run != 0) begin chk("R11", "we low cycles", we_run, WP_EXP); we_run = 0; end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one access; optionally keep a junk request up while busy (R8)
  task automatic access(bit w, logic [16:0] a, logic [7:0] d, bit junk);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    if (junk) begin addr = a ^ 17'h1_5555; wdata = ~d; we = ~w; end
    else req = 0;
    while (!done) @(negedge clk);
    req = 0;
  endtask

  int issued = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    access(1, 17'h00000, 8'h3C, 0); issued++;
    access(1, 17'h1FFFF, 8'hC3, 0); issued++;
    access(0, 17'h00000, 8'h00, 0); issued++;
    access(0, 17'h1FFFF, 8'h00, 0); issued++;  // read-read
    access(1, 17'h0A5A5, 8'h81, 0); issued++;  // read-write turnaround
    access(1, 17'h0A5A6, 8'h7E, 0); issued++;  // write-write, no turnaround
    access(0, 17'h0A5A5, 8'h00, 1); issued++;  // busy requests ignored
    access(0, 17'h12345, 8'h00, 0); issued++;  // never written
    access(1, 17'h12345, 8'hFF, 1); issued++;
    access(0, 17'h12345, 8'h00, 0); issued++;
    access(0, 17'h0A5A6, 8'h00, 0); issued++;
    for (int i = 0; i < 8; i++) begin
      access(1, 17'(i * 16411), 8'(i * 37 + 1), 0); issued++;
    end
    for (int i = 0; i < 8; i++) begin
      access(0, 17'(i * 16411), 8'h00, 0); issued++;
    end
    repeat (4) @(negedge clk);
    chk("R8", "done pulses", dones, issued);
    chk("R8", "idle after run", ready, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule